// File: doc/BRIEF.md
# I/O Interrupt Redirection Router

This block is the routing stage of an I/O interrupt controller. Each input line has a redirection entry, presented as a packed input word, that holds a vector, a delivery mode, a destination mode, a polarity, a trigger and an 8-bit destination. When a line event is accepted, the router reads that line's entry and turns it into a set of target local controllers, up to `NUM_CTX` of them. It then sends one message for each target on a valid/ready output port.

In physical mode the destination is a controller ID, and the value 0xFF is a broadcast. In logical mode, each controller's logical destination register is supplied on an input array. A controller is a target when the top byte of its register shares at least one set bit with the destination. Lowest-priority and reserved delivery encodings are refused: the router raises an error pulse and sends nothing.

Line events that arrive while a target set is still draining are held pending. Once the router is idle they are served, lowest line number first. Edge and level detection of the lines, writes to the entry registers and the transport after the port are handled outside this block.

Top module: `irq_route_top`

## Requirements
- R1: An entry is packed as vector [7:0], delivery mode [10:8], destination mode [11] (0 physical, 1 logical), polarity [12], trigger [13] and destination [21:14]. Every message carries the entry's vector, delivery mode and destination mode, with polarity on `msg_level` and trigger on `msg_trig`.
- R2: In physical mode, destination 0xFF targets every ID below `ctx_count`.
- R3: In physical mode, any other destination targets only that ID, and only if it is below `ctx_count`. Otherwise the set is empty.
- R4: In logical mode, controller i is targeted when i < `ctx_count` and bits 31:24 of its logical destination register ANDed with the destination are nonzero.
- R5: Delivery mode 3'b001 (lowest priority) pulses `route_err` for one cycle and sends no message, in either destination mode.
- R6: Reserved delivery modes 3'b011 and 3'b110 act the same as R5. No message is ever sent with a refused delivery mode.
- R7: One message is sent per target, in ascending ID order. While `msg_ready` is low, a valid message keeps its ID and fields unchanged.
- R8: Line events that arrive while the router is busy are held pending. Each is served once, lowest line number first, after the current set drains.
- R9: An empty target set takes one cycle. The next pending event is accepted on the following clock edge.
- R10: Under reset, `msg_valid` and `route_err` are low.
- R11: If a line event is sampled at clock edge k, its first message, or its error pulse, is visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_fire | input | NUM_LINES | One-cycle event per interrupt line |
| rte_flat | input | NUM_LINES*22 | Redirection entries, line 0 in the low bits |
| ldr_flat | input | NUM_CTX*32 | Logical destination register of each controller, controller 0 in the low bits |
| ctx_count | input | CNT_W | Number of controllers present |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_valid | output | 1 | Message present |
| msg_id | output | ID_W | Target controller ID |
| msg_vector | output | 8 | Interrupt vector |
| msg_dlv | output | 3 | Delivery mode |
| msg_dmode | output | 1 | Destination mode |
| msg_level | output | 1 | Polarity of the entry |
| msg_trig | output | 1 | Trigger mode |
| route_err | output | 1 | One-cycle pulse for a refused delivery mode |

## Verification
Some behaviour is checked by assertions on every cycle. A stalled message holds still, IDs within one set rise, an error never coincides with a message, refused delivery modes never appear on the port, and a pending line is not lost. Other behaviour can only be shown by the bench's scenarios: which targets each mode resolves to, the field mapping, the serving order across lines, and the cycle on which a set starts or an empty set finishes.

// File: rtl/irq_route_pkg.sv
// Shared types for the interrupt router.
// Assumes an 8-bit vector and destination and a 3-bit delivery mode.
package irq_route_pkg;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int DLV_W  = 3;
    localparam int LDR_W  = 32;

    // Redirection entry: the first member sits in the most significant bits
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              trig;
        logic              pol;
        logic              dmode;
        logic [DLV_W-1:0]  dlv;
        logic [VEC_W-1:0]  vec;
    } rte_t;

    localparam int RTE_W = $bits(rte_t);

    // Fields carried by each outgoing message
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [DLV_W-1:0] dlv;
        logic             dmode;
        logic             level;
        logic             trig;
    } msg_t;

    // Delivery encodings the router refuses: lowest priority and the two reserved codes
    function automatic logic dlv_refused(input logic [DLV_W-1:0] d);
        return (d == 3'b001) || (d == 3'b011) || (d == 3'b110);
    endfunction
endpackage

// File: rtl/irq_pending_arb.sv
// Holds line events until the router can take them.
// Grants the lowest-numbered pending line whenever take is high.
// Assumes that events on a line which is already pending merge into one.
module irq_pending_arb #(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] fire,
    input  logic                 take,
    output logic                 grant_vld,
    output logic [IDX_W-1:0]     grant_idx
);
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] clr;

    // Find the lowest pending line
    always_comb begin
        grant_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend[i]) grant_idx = IDX_W'(i);
        end
    end

    assign grant_vld = take && (|pend);

    // One-hot clear mask for the granted line
    always_comb begin
        clr = '0;
        if (grant_vld) clr[grant_idx] = 1'b1;
    end

    // Record new events and drop the one being granted
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | fire;
    end

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_keep
            // R8
            pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[g] && !clr[g]) |=> pend[g]);
        end
    endgenerate
endmodule

// File: rtl/irq_target_resolve.sv
// Turns one redirection entry into a target mask over the controllers.
// Purely combinational. Indices at or above ctx_count are never targeted.
module irq_target_resolve
    import irq_route_pkg::*;
#(
    parameter int NUM_CTX = 8,
    localparam int CNT_W = $clog2(NUM_CTX + 1)
) (
    input  rte_t                     ent,
    input  logic [NUM_CTX*LDR_W-1:0] ldr_flat,
    input  logic [CNT_W-1:0]         ctx_count,
    output logic [NUM_CTX-1:0]       mask,
    output logic                     refused
);
    assign refused = dlv_refused(ent.dlv);

    generate
        for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
            logic present;
            logic [DEST_W-1:0] ldr_top;
            assign present = (CNT_W'(i) < ctx_count);
            assign ldr_top = ldr_flat[i*LDR_W + LDR_W - 1 -: DEST_W];
            // Decide whether controller i belongs to the target set
            always_comb begin
                if (refused || !present)  mask[i] = 1'b0;
                else if (ent.dmode)       mask[i] = |(ldr_top & ent.dest);
                else if (ent.dest == '1)  mask[i] = 1'b1;
                else                      mask[i] = (ent.dest == DEST_W'(i));
            end
        end
    endgenerate
endmodule

// File: rtl/irq_msg_walker.sv
// Walks a target mask and sends one message per set bit, lowest ID first.
// A load is only taken while idle; an all-zero mask leaves it idle.
module irq_msg_walker
    import irq_route_pkg::*;
#(
    parameter int NUM_CTX = 8,
    localparam int ID_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NUM_CTX-1:0] load_mask,
    input  msg_t               load_msg,
    input  logic               ready,
    output logic               idle,
    output logic               valid,
    output logic [ID_W-1:0]    id,
    output msg_t               msg
);
    logic               busy;
    logic [NUM_CTX-1:0] mask;

    // Pick the lowest remaining target
    always_comb begin
        id = '0;
        for (int i = NUM_CTX - 1; i >= 0; i--) begin
            if (mask[i]) id = ID_W'(i);
        end
    end

    assign valid = busy;
    assign idle  = !busy;

    // Load a new set, or retire one target per handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            mask <= '0;
            msg  <= '0;
        end else if (load && !busy) begin
            busy <= |load_mask;
            mask <= load_mask;
            msg  <= load_msg;
        end else if (busy && ready) begin
            mask[id] <= 1'b0;
            if ($countones(mask) == 1) busy <= 1'b0;
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready) |=> (busy && $stable(id) && $stable(msg)));

    // R7
    id_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready && ($countones(mask) > 1)) |=> (busy && (id > $past(id))));
endmodule

// File: rtl/irq_route_top.sv
// I/O interrupt router: takes line events, resolves each line's redirection
// entry into a set of target controllers and sends one message per target.
// Assumes that ctx_count and ldr_flat stay steady while a set is resolved.
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int NUM_CTX   = 8,
    localparam int CNT_W = $clog2(NUM_CTX + 1),
    localparam int ID_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LINES-1:0]     line_fire,
    input  logic [NUM_LINES*22-1:0]  rte_flat,
    input  logic [NUM_CTX*32-1:0]    ldr_flat,
    input  logic [CNT_W-1:0]         ctx_count,
    input  logic                     msg_ready,
    output logic                     msg_valid,
    output logic [ID_W-1:0]          msg_id,
    output logic [7:0]               msg_vector,
    output logic [2:0]               msg_dlv,
    output logic                     msg_dmode,
    output logic                     msg_level,
    output logic                     msg_trig,
    output logic                     route_err
);
    logic               grant_vld;
    logic [IDX_W-1:0]   grant_idx;
    logic               walk_idle;
    rte_t               ent;
    logic [NUM_CTX-1:0] tgt_mask;
    logic               refused;
    msg_t               new_msg;
    msg_t               cur_msg;
    logic               err_q;

    irq_pending_arb #(.NUM_LINES(NUM_LINES)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (line_fire),
        .take      (walk_idle),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    assign ent = rte_t'(rte_flat[grant_idx*RTE_W +: RTE_W]);

    irq_target_resolve #(.NUM_CTX(NUM_CTX)) u_resolve (
        .ent       (ent),
        .ldr_flat  (ldr_flat),
        .ctx_count (ctx_count),
        .mask      (tgt_mask),
        .refused   (refused)
    );

    // Copy the entry fields into the message layout
    always_comb begin
        new_msg.vec   = ent.vec;
        new_msg.dlv   = ent.dlv;
        new_msg.dmode = ent.dmode;
        new_msg.level = ent.pol;
        new_msg.trig  = ent.trig;
    end

    irq_msg_walker #(.NUM_CTX(NUM_CTX)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (grant_vld),
        .load_mask (tgt_mask),
        .load_msg  (new_msg),
        .ready     (msg_ready),
        .idle      (walk_idle),
        .valid     (msg_valid),
        .id        (msg_id),
        .msg       (cur_msg)
    );

    // One-cycle error pulse when a granted entry is refused
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= grant_vld && refused;
    end

    assign route_err  = err_q;
    assign msg_vector = cur_msg.vec;
    assign msg_dlv    = cur_msg.dlv;
    assign msg_dmode  = cur_msg.dmode;
    assign msg_level  = cur_msg.level;
    assign msg_trig   = cur_msg.trig;

    // R5
    err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |-> !msg_valid);

    // R6
    no_refused_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !dlv_refused(msg_dlv));
endmodule

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;
    import irq_route_pkg::*;

    localparam int NL = 4;
    localparam int NC = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   line_fire = '0;
    logic [NL*22-1:0] rte_flat = '0;
    logic [NC*32-1:0] ldr_flat = '0;
    logic [3:0]      ctx_count = 4'd8;
    logic            msg_ready = 1'b1;
    logic            msg_valid;
    logic [2:0]      msg_id;
    logic [7:0]      msg_vector;
    logic [2:0]      msg_dlv;
    logic            msg_dmode, msg_level, msg_trig, route_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_route_top #(.NUM_LINES(NL), .NUM_CTX(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_fire(line_fire), .rte_flat(rte_flat),
        .ldr_flat(ldr_flat), .ctx_count(ctx_count), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_id(msg_id), .msg_vector(msg_vector),
        .msg_dlv(msg_dlv), .msg_dmode(msg_dmode), .msg_level(msg_level),
        .msg_trig(msg_trig), .route_err(route_err)
    );

    // Top bytes of each controller's logical destination register
    localparam logic [7:0] LTOP [0:7] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h30, 8'h00, 8'hFF, 8'h80};

    // Vector: {dest mode, destination, delivery mode, context count}
    localparam int NV = 14;
    localparam logic [15:0] VTAB [0:NV-1] = '{
        {1'b0, 8'hFF, 3'd0, 4'd8}, {1'b0, 8'hFF, 3'd0, 4'd5},
        {1'b0, 8'h03, 3'd4, 4'd8}, {1'b0, 8'h09, 3'd0, 4'd8},
        {1'b0, 8'h06, 3'd0, 4'd6}, {1'b1, 8'h01, 3'd0, 4'd8},
        {1'b1, 8'h30, 3'd5, 4'd8}, {1'b1, 8'h80, 3'd0, 4'd7},
        {1'b1, 8'h00, 3'd0, 4'd8}, {1'b0, 8'hFF, 3'd1, 4'd8},
        {1'b1, 8'h0F, 3'd1, 4'd8}, {1'b0, 8'h02, 3'd3, 4'd8},
        {1'b1, 8'hFF, 3'd6, 4'd8}, {1'b0, 8'h00, 3'd7, 4'd8}
    };

    function automatic bit is_bad(input logic [2:0] d);
        return d == 3'd1 || d == 3'd3 || d == 3'd6;
    endfunction

    // Expected target set, written from R2, R3, R4, R5 and R6
    function automatic logic [7:0] exp_mask(input logic dm, input logic [7:0] dst,
                                            input logic [2:0] dl, input logic [3:0] n);
        logic [7:0] m = '0;
        if (is_bad(dl)) return m;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(n)) begin
                if (dm)               m[i] = (LTOP[i] & dst) != 0;
                else if (dst == 8'hFF) m[i] = 1'b1;
                else                  m[i] = (int'(dst) == i);
            end
        end
        return m;
    endfunction

    function automatic string tag_of(input logic dm, input logic [7:0] dst, input logic [2:0] dl);
        if (dl == 3'd1) return "R5";
        if (is_bad(dl)) return "R6";
        if (dm) return "R4";
        if (dst == 8'hFF) return "R2";
        return "R3";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_rte(input int line, input logic dm, input logic [7:0] dst,
                           input logic [2:0] dl, input logic [7:0] vec,
                           input logic pol, input logic trg);
        rte_t e;
        e.dest = dst; e.trig = trg; e.pol = pol; e.dmode = dm; e.dlv = dl; e.vec = vec;
        rte_flat[line*22 +: 22] = e;
    endtask

    task automatic fire_lines(input logic [NL-1:0] f);
        line_fire = f;
        @(negedge clk);
        line_fire = '0;
    endtask

    task automatic run_vec(input int k);
        logic [15:0] v;
        logic dm; logic [7:0] dst; logic [2:0] dl; logic [3:0] n;
        logic [7:0] em, got;
        logic [7:0] vec;
        bit fld_ok, ord_ok, err_now, err_late;
        int prev;
        v = VTAB[k];
        {dm, dst, dl, n} = v;
        vec = 8'h40 + 8'(k);
        em = exp_mask(dm, dst, dl, n);
        set_rte(0, dm, dst, dl, vec, k[0], k[1]);
        ctx_count = n;
        msg_ready = 1'b1;
        @(negedge clk);
        fire_lines(4'b0001);
        @(negedge clk);
        got = '0; fld_ok = 1; ord_ok = 1; prev = -1; err_late = 0;
        err_now = route_err;
        // R11: the set must start on this very cycle
        if (em != 0 && !msg_valid) ord_ok = 0;
        for (int c = 0; c < 12; c++) begin
            if (msg_valid) begin
                if (int'(msg_id) <= prev) ord_ok = 0;
                prev = int'(msg_id);
                got[msg_id] = 1'b1;
                if (msg_vector != vec || msg_dlv != dl || msg_dmode != dm ||
                    msg_level != k[0] || msg_trig != k[1]) fld_ok = 0;
            end
            if (c > 0 && route_err) err_late = 1;
            @(negedge clk);
        end
        chk(got == em, tag_of(dm, dst, dl), $sformatf("target set vector %0d", k), got, em);
        chk(fld_ok, "R1", $sformatf("message fields vector %0d", k), fld_ok, 1);
        chk(ord_ok, "R7/R11", $sformatf("order and start cycle vector %0d", k), ord_ok, 1);
        chk(err_now == is_bad(dl) && !err_late, is_bad(dl) ? "R5/R6" : "R11",
            $sformatf("error pulse vector %0d", k), err_now, is_bad(dl));
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R11: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seq [0:15];
        int cnt;
        bit ok;
        for (int i = 0; i < NC; i++) ldr_flat[i*32 +: 32] = {LTOP[i], 24'h00_1234};
        repeat (3) @(negedge clk);
        // R10: outputs quiet during reset
        chk(!msg_valid && !route_err, "R10", "reset outputs", {msg_valid, route_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) run_vec(k);

        // R7: back-pressure holds the message steady
        ctx_count = 4'd3;
        set_rte(0, 1'b0, 8'hFF, 3'd0, 8'hA0, 1'b0, 1'b0);
        msg_ready = 1'b0;
        fire_lines(4'b0001);
        @(negedge clk);
        chk(msg_valid && msg_id == 0, "R7", "first under stall", msg_id, 0);
        @(negedge clk);
        @(negedge clk);
        chk(msg_valid && msg_id == 0 && msg_vector == 8'hA0, "R7", "held under stall", msg_id, 0);
        msg_ready = 1'b1;
        @(negedge clk);
        chk(msg_valid && msg_id == 1, "R7", "after release", msg_id, 1);
        @(negedge clk);
        @(negedge clk);
        chk(!msg_valid, "R7", "set drained", msg_valid, 0);

        // R8: events arriving while busy are served lowest line first
        ctx_count = 4'd8;
        set_rte(0, 1'b0, 8'hFF, 3'd0, 8'h80, 1'b0, 1'b0);
        set_rte(1, 1'b0, 8'h01, 3'd0, 8'h81, 1'b0, 1'b0);
        set_rte(2, 1'b0, 8'h02, 3'd0, 8'h82, 1'b0, 1'b0);
        set_rte(3, 1'b0, 8'h03, 3'd0, 8'h83, 1'b0, 1'b0);
        fire_lines(4'b0001);
        fire_lines(4'b1110);
        cnt = 0;
        for (int c = 0; c < 30; c++) begin
            if (msg_valid && cnt < 16) begin
                seq[cnt] = int'(msg_vector) * 16 + int'(msg_id);
                cnt++;
            end
            @(negedge clk);
        end
        ok = (cnt == 11);
        for (int i = 0; i < 8; i++) if (ok && seq[i] != 16'h800 + i) ok = 0;
        for (int i = 1; i < 4; i++) if (ok && seq[7 + i] != (16'h80 + i) * 16 + i) ok = 0;
        chk(ok, "R8", "pending service order (message count)", cnt, 11);

        // R9: an empty set finishes in one cycle, the next line follows at once
        set_rte(0, 1'b0, 8'h09, 3'd0, 8'h90, 1'b0, 1'b0);
        set_rte(1, 1'b0, 8'h05, 3'd0, 8'h91, 1'b0, 1'b0);
        fire_lines(4'b0011);
        @(negedge clk);
        chk(!msg_valid && !route_err, "R9", "empty set sends nothing", msg_valid, 0);
        @(negedge clk);
        chk(msg_valid && msg_id == 5 && msg_vector == 8'h91, "R9", "next line one cycle later",
            {msg_valid, msg_vector}, {1'b1, 8'h91});
        @(negedge clk);
        chk(!msg_valid, "R3", "single target sends once", msg_valid, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule